// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which oscillator clocks the CPU and which oscillators run. There are two: a high-speed main oscillator and an internal ring oscillator. It keeps three software control bits: main oscillator off, CPU select main, and ring oscillator off. Software changes them with a single write strobe. The block accepts only writes that move between neighbouring run states, and only while the interlocks allow the move. These interlocks are a clock-status bit that trails the select by one cycle, and a qualified stabilization flag for the main oscillator. A write that asks for any other move is dropped and sets a sticky error flag.

HALT and STOP strobes put the block into a low-power mode from any run state. A wake input returns it to the run state it left. STOP shuts the main oscillator down and throws away the stabilization qualification. A strap input chooses whether software may stop the ring oscillator. When it may, the watchdog clock enable is removed during HALT and STOP. Any of several reset sources forces the ring-only run state.

Top module: `clk_src_ctrl`

## Requirements
- R1: While any bit of `rstSrc` is high (bit 0 pin, bit 1 power-on, bit 2 low-voltage, bit 3 clock monitor, bit 4 watchdog), the next clock edge gives state code 1, `mainOscEn`=0, `ringOscEn`=1, `cpuClkSel`=0, `clkStat`=0, `errFlag`=0 and `wdtClkEn`=1.
- R2: `stateCode` reads 1 for ring-only, 2 for both oscillators with the CPU on the ring, 3 for both oscillators with the CPU on main, 4 for main-only, 5 for HALT and 6 for STOP. `ringOscEn` is low in state 4, and `mainOscEn` is high in states 2 to 4.
- R3: With `ctlWr` high, the bits {`ctlMainOff`,`ctlSelMain`,`ctlRingOff`} select a target. Here 100 is state 1, 000 is state 2, 010 is state 3 and 011 is state 4. A move from 1 to 2 is always taken. A move from 2 to 1 is taken only when `clkStat`=0.
- R4: A move from 2 to 3 is taken only when the stabilization qualification is set. A rising edge of `stabDone`, seen while `mainOscEn`=1, sets it. Reset, STOP entry or an accepted write that stops the main oscillator clears it.
- R5: A move from 3 to 4 is taken only when `clkStat`=1 and `strapRingSw`=1. Moves from 4 to 3 and from 3 to 2 are always taken.
- R6: A run-state write whose bits differ from the current ones is an illegal request when it is not a permitted move. Such a write leaves the state unchanged and sets `errFlag`, which stays set until reset. A write that repeats the current bits is not an error.
- R7: `clkStat` equals the value `cpuClkSel` had one cycle earlier.
- R8: In a run state, `stopReq` enters STOP and `haltReq` enters HALT, with STOP taking priority. In HALT or STOP, `wakeReq` returns to the run state that was left. Mode strobes and writes are ignored there and do not set `errFlag`, and `wakeReq` has no effect in a run state.
- R9: In STOP `mainOscEn` is 0. After waking, a move from 2 to 3 is rejected until a fresh `stabDone` rising edge.
- R10: With `strapRingSw`=1, `wdtClkEn` is 0 in HALT and STOP, and `ringOscEn` keeps the inverse of the ring-off bit in both modes.
- R11: With `strapRingSw`=0, `wdtClkEn` and `ringOscEn` are always 1, and a write that sets the ring-off bit is rejected as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSrc | input | 5 | Reset sources, active high, OR-combined |
| strapRingSw | input | 1 | Strap: 1 lets software stop the ring oscillator |
| ctlWr | input | 1 | Control write strobe |
| ctlMainOff | input | 1 | Write data: main oscillator off |
| ctlSelMain | input | 1 | Write data: CPU clock from main oscillator |
| ctlRingOff | input | 1 | Write data: ring oscillator off |
| haltReq | input | 1 | HALT instruction strobe |
| stopReq | input | 1 | STOP instruction strobe |
| wakeReq | input | 1 | Interrupt wake |
| stabDone | input | 1 | Main oscillator stabilization done flag |
| mainOscEn | output | 1 | Main oscillator enable |
| ringOscEn | output | 1 | Ring oscillator enable |
| cpuClkSel | output | 1 | CPU clock select, 1 = main |
| clkStat | output | 1 | Current CPU source status, 1 = main |
| wdtClkEn | output | 1 | Watchdog clock enable |
| stateCode | output | 3 | Current state code |
| errFlag | output | 1 | Sticky illegal-request flag |

## Verification
The transition checks are tried three ways. First, a write is made right after its interlock changes, where `clkStat` still lags by one cycle. Second, the same write is made one cycle later. These two cases separate an interlock read from the registered status from one read from the request. Third, a write is made with no stabilization edge, then after a fresh edge, then after a STOP. This shows whether the qualification is set by an edge and cleared on STOP. Low-power entry is tried from different run states and under both strap values. This separates the return-to-origin path and the watchdog gating from a fixed return state or an ungated enable.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_R1   = 3'd1,
    ST_R2   = 3'd2,
    ST_R3   = 3'd3,
    ST_R4   = 3'd4,
    ST_HALT = 3'd5,
    ST_STOP = 3'd6
  } clkState_e;

  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_HALT = 2'd1,
    LP_STOP = 2'd2
  } lpMode_e;

  typedef struct packed {
    logic mainOff;
    logic selMain;
    logic ringOff;
  } swBits_t;

  typedef struct packed {
    logic wrTake;
    logic wrBad;
    logic goHalt;
    logic goStop;
    logic wake;
  } ctlStrb_t;

  localparam swBits_t RESET_BITS = '{mainOff: 1'b1, selMain: 1'b0, ringOff: 1'b0};

  function automatic clkState_e bitsToRun(swBits_t b);
    case ({b.mainOff, b.selMain, b.ringOff})
      3'b100:  return ST_R1;
      3'b000:  return ST_R2;
      3'b010:  return ST_R3;
      3'b011:  return ST_R4;
      default: return ST_NONE;
    endcase
  endfunction

  function automatic logic moveOk(clkState_e src, clkState_e dst,
                                  logic stat, logic qual, logic strap);
    case ({src, dst})
      {ST_R1, ST_R2}: return 1'b1;
      {ST_R2, ST_R1}: return !stat;
      {ST_R2, ST_R3}: return qual;
      {ST_R3, ST_R2}: return 1'b1;
      {ST_R3, ST_R4}: return stat && strap;
      {ST_R4, ST_R3}: return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/clk_src_fsm.sv
module clk_src_fsm
  import clk_src_pkg::*;
(
  input  lpMode_e  lpMode,
  input  logic     wr,
  input  swBits_t  wrBits,
  input  swBits_t  curBits,
  input  logic     haltReq,
  input  logic     stopReq,
  input  logic     wakeReq,
  input  logic     clkStat,
  input  logic     stabQual,
  input  logic     strap,
  output ctlStrb_t strb
);

  clkState_e curRun;
  clkState_e tgtRun;
  logic      inRun;
  logic      isChange;

  always_comb begin
    curRun   = bitsToRun(curBits);
    tgtRun   = bitsToRun(wrBits);
    inRun    = (lpMode == LP_RUN);
    isChange = (wrBits != curBits);
    strb     = '0;
    if (inRun) begin
      strb.goStop = stopReq;
      strb.goHalt = haltReq && !stopReq;
      if (wr && isChange) begin
        if (moveOk(curRun, tgtRun, clkStat, stabQual, strap)) strb.wrTake = 1'b1;
        else                                                 strb.wrBad  = 1'b1;
      end
    end else begin
      strb.wake = wakeReq;
    end
  end

endmodule

// File: rtl/clk_src_dp.sv
module clk_src_dp
  import clk_src_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ctlStrb_t strb,
  input  swBits_t  wrBits,
  input  logic     stabDone,
  input  logic     strap,
  output lpMode_e  lpMode,
  output swBits_t  curBits,
  output logic     clkStat,
  output logic     stabQual,
  output logic     errFlag,
  output logic     mainOscEn,
  output logic     ringOscEn,
  output logic     cpuClkSel,
  output logic     wdtClkEn,
  output logic [2:0] stateCode
);

  swBits_t bitsQ;
  lpMode_e lpQ;
  logic    statQ;
  logic    stabPrevQ;
  logic    qualQ;
  logic    errQ;
  logic    stabEdge;
  logic    qualClr;

  always_ff @(posedge clk) begin
    if (rst)              bitsQ <= RESET_BITS;
    else if (strb.wrTake) bitsQ <= wrBits;
  end

  always_ff @(posedge clk) begin
    if (rst)              lpQ <= LP_RUN;
    else if (strb.goStop) lpQ <= LP_STOP;
    else if (strb.goHalt) lpQ <= LP_HALT;
    else if (strb.wake)   lpQ <= LP_RUN;
  end

  // Source status trails the select by one cycle (switch handshake).
  always_ff @(posedge clk) begin
    if (rst) statQ <= 1'b0;
    else     statQ <= bitsQ.selMain;
  end

  assign stabEdge = stabDone && !stabPrevQ && mainOscEn;
  assign qualClr  = strb.goStop || (strb.wrTake && wrBits.mainOff);

  always_ff @(posedge clk) begin
    if (rst) begin
      stabPrevQ <= 1'b0;
      qualQ     <= 1'b0;
    end else begin
      stabPrevQ <= stabDone;
      if (qualClr)       qualQ <= 1'b0;
      else if (stabEdge) qualQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             errQ <= 1'b0;
    else if (strb.wrBad) errQ <= 1'b1;
  end

  always_comb begin
    case (lpQ)
      LP_HALT: stateCode = ST_HALT;
      LP_STOP: stateCode = ST_STOP;
      default: stateCode = bitsToRun(bitsQ);
    endcase
  end

  assign lpMode    = lpQ;
  assign curBits   = bitsQ;
  assign clkStat   = statQ;
  assign stabQual  = qualQ;
  assign errFlag   = errQ;
  assign cpuClkSel = bitsQ.selMain;
  assign mainOscEn = !bitsQ.mainOff && (lpQ != LP_STOP);
  assign ringOscEn = strap ? !bitsQ.ringOff : 1'b1;
  assign wdtClkEn  = !(strap && (lpQ != LP_RUN));

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int RST_SRC_N = 5
) (
  input  logic                 clk,
  input  logic [RST_SRC_N-1:0] rstSrc,
  input  logic                 strapRingSw,
  input  logic                 ctlWr,
  input  logic                 ctlMainOff,
  input  logic                 ctlSelMain,
  input  logic                 ctlRingOff,
  input  logic                 haltReq,
  input  logic                 stopReq,
  input  logic                 wakeReq,
  input  logic                 stabDone,
  output logic                 mainOscEn,
  output logic                 ringOscEn,
  output logic                 cpuClkSel,
  output logic                 clkStat,
  output logic                 wdtClkEn,
  output logic [2:0]           stateCode,
  output logic                 errFlag
);

  logic     anyRst;
  swBits_t  wrBits;
  swBits_t  curBits;
  lpMode_e  lpMode;
  ctlStrb_t strb;
  logic     stabQual;
  logic     statInt;

  assign anyRst = |rstSrc;
  assign wrBits = '{mainOff: ctlMainOff, selMain: ctlSelMain, ringOff: ctlRingOff};

  clk_src_fsm fsm_i (
    .lpMode  (lpMode),
    .wr      (ctlWr),
    .wrBits  (wrBits),
    .curBits (curBits),
    .haltReq (haltReq),
    .stopReq (stopReq),
    .wakeReq (wakeReq),
    .clkStat (statInt),
    .stabQual(stabQual),
    .strap   (strapRingSw),
    .strb    (strb)
  );

  clk_src_dp dp_i (
    .clk      (clk),
    .rst      (anyRst),
    .strb     (strb),
    .wrBits   (wrBits),
    .stabDone (stabDone),
    .strap    (strapRingSw),
    .lpMode   (lpMode),
    .curBits  (curBits),
    .clkStat  (statInt),
    .stabQual (stabQual),
    .errFlag  (errFlag),
    .mainOscEn(mainOscEn),
    .ringOscEn(ringOscEn),
    .cpuClkSel(cpuClkSel),
    .wdtClkEn (wdtClkEn),
    .stateCode(stateCode)
  );

  assign clkStat = statInt;

endmodule

// File: rtl/clk_src_chk.sv
module clk_src_chk #(
  parameter int RST_SRC_N = 5
) (
  input logic                 clk,
  input logic [RST_SRC_N-1:0] rstSrc,
  input logic                 strapRingSw,
  input logic                 wakeReq,
  input logic                 mainOscEn,
  input logic                 cpuClkSel,
  input logic                 clkStat,
  input logic                 wdtClkEn,
  input logic [2:0]           stateCode,
  input logic                 errFlag
);

  // R1
  rst_state_chk: assert property (@(posedge clk)
    (|rstSrc) |=> (stateCode == 3'd1 && !mainOscEn && !errFlag));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    (stateCode >= 3'd1 && stateCode <= 3'd6));

  // R5
  main_only_entry_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    (stateCode == 3'd4 && $past(stateCode) != 3'd4) |->
      ($past(stateCode) == 3'd3 || $past(stateCode) == 3'd5 || $past(stateCode) == 3'd6));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    errFlag |=> errFlag);

  // R7
  stat_lag_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    1'b1 |=> (clkStat == $past(cpuClkSel)));

  // R8
  lp_hold_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    ((stateCode == 3'd5 || stateCode == 3'd6) && !wakeReq) |=> (stateCode == $past(stateCode)));

  // R9
  stop_main_off_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    (stateCode == 3'd6) |-> !mainOscEn);

  // R10
  wdt_gate_chk: assert property (@(posedge clk) disable iff (|rstSrc)
    !wdtClkEn |-> (strapRingSw && (stateCode == 3'd5 || stateCode == 3'd6)));

endmodule

bind clk_src_ctrl clk_src_chk #(.RST_SRC_N(RST_SRC_N)) chk_i (
  .clk        (clk),
  .rstSrc     (rstSrc),
  .strapRingSw(strapRingSw),
  .wakeReq    (wakeReq),
  .mainOscEn  (mainOscEn),
  .cpuClkSel  (cpuClkSel),
  .clkStat    (clkStat),
  .wdtClkEn   (wdtClkEn),
  .stateCode  (stateCode),
  .errFlag    (errFlag)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic [4:0] rstSrc = 5'b00001;
  logic       strapRingSw = 1'b1;
  logic       ctlWr = 1'b0, ctlMainOff = 1'b1, ctlSelMain = 1'b0, ctlRingOff = 1'b0;
  logic       haltReq = 1'b0, stopReq = 1'b0, wakeReq = 1'b0, stabDone = 1'b0;
  logic       mainOscEn, ringOscEn, cpuClkSel, clkStat, wdtClkEn, errFlag;
  logic [2:0] stateCode;

  int nChecks = 0;
  int nFail   = 0;
  int nCycles = 0;
  bit doneRun = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_ctrl dut_i (
    .clk(clk), .rstSrc(rstSrc), .strapRingSw(strapRingSw),
    .ctlWr(ctlWr), .ctlMainOff(ctlMainOff), .ctlSelMain(ctlSelMain), .ctlRingOff(ctlRingOff),
    .haltReq(haltReq), .stopReq(stopReq), .wakeReq(wakeReq), .stabDone(stabDone),
    .mainOscEn(mainOscEn), .ringOscEn(ringOscEn), .cpuClkSel(cpuClkSel), .clkStat(clkStat),
    .wdtClkEn(wdtClkEn), .stateCode(stateCode), .errFlag(errFlag)
  );

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    nCycles++;
    if (nCycles > WATCHDOG && !doneRun) begin
      doneRun = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", nCycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic m, logic s, logic r);
    ctlWr = 1'b1; ctlMainOff = m; ctlSelMain = s; ctlRingOff = r;
    cyc(1);
    ctlWr = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  task automatic doReset(int idx);
    rstSrc = 5'b1 << idx;
    cyc(2);
    rstSrc = '0;
  endtask

  task automatic goState3();
    doWrite(0, 0, 0);
    pulse(stabDone);
    doWrite(0, 1, 0);
    cyc(1);
  endtask

  task automatic tReset();
    cyc(3);
    rstSrc = '0;
    chk("R1 code", stateCode, 1);
    chk("R1 mainOscEn", mainOscEn, 0);
    chk("R1 ringOscEn", ringOscEn, 1);
    chk("R1 cpuClkSel", cpuClkSel, 0);
    chk("R1 clkStat", clkStat, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 wdtClkEn", wdtClkEn, 1);
  endtask

  task automatic tMainOsc();
    doWrite(0, 0, 0);
    chk("R3 1to2 code", stateCode, 2);
    chk("R2 mainOscEn in 2", mainOscEn, 1);
    doWrite(1, 0, 0);
    chk("R3 2to1 code", stateCode, 1);
    chk("R3 no error", errFlag, 0);
  endtask

  task automatic tSelect();
    doReset(1);
    doWrite(0, 0, 0);
    doWrite(0, 1, 0);
    chk("R4 unqualified code", stateCode, 2);
    chk("R4 unqualified err", errFlag, 1);
    doReset(2);
    chk("R1 err cleared", errFlag, 0);
    doWrite(0, 0, 0);
    pulse(stabDone);
    doWrite(0, 1, 0);
    chk("R4 qualified code", stateCode, 3);
    chk("R7 sel now", cpuClkSel, 1);
    chk("R7 stat lags", clkStat, 0);
    cyc(1);
    chk("R7 stat follows", clkStat, 1);
  endtask

  task automatic tRing();
    doReset(0);
    doWrite(0, 0, 0);
    pulse(stabDone);
    doWrite(0, 1, 0);
    doWrite(0, 1, 1);
    chk("R5 early reject code", stateCode, 3);
    chk("R5 early reject err", errFlag, 1);
    doWrite(0, 1, 1);
    chk("R5 3to4 code", stateCode, 4);
    chk("R2 ring off in 4", ringOscEn, 0);
    chk("R2 main on in 4", mainOscEn, 1);
    chk("R6 err sticky", errFlag, 1);
    doWrite(0, 1, 0);
    chk("R5 4to3 code", stateCode, 3);
    chk("R5 ring back", ringOscEn, 1);
    doWrite(0, 0, 0);
    chk("R5 3to2 code", stateCode, 2);
    doWrite(1, 0, 0);
    chk("R3 2to1 while stat=1", stateCode, 2);
    cyc(1);
    doWrite(1, 0, 0);
    chk("R3 2to1 after stat=0", stateCode, 1);
  endtask

  task automatic tIllegal();
    doReset(3);
    doWrite(0, 1, 0);
    chk("R6 jump code", stateCode, 1);
    chk("R6 jump err", errFlag, 1);
    chk("R6 jump sel", cpuClkSel, 0);
    doReset(4);
    doWrite(1, 0, 0);
    chk("R6 repeat no err", errFlag, 0);
    chk("R6 repeat code", stateCode, 1);
  endtask

  task automatic tHalt();
    doReset(0);
    goState3();
    pulse(haltReq);
    chk("R8 halt code", stateCode, 5);
    chk("R10 wdt off halt", wdtClkEn, 0);
    chk("R10 ring on halt", ringOscEn, 1);
    chk("R8 main on halt", mainOscEn, 1);
    doWrite(0, 0, 0);
    chk("R8 write ignored code", stateCode, 5);
    pulse(stopReq);
    chk("R8 stop ignored in halt", stateCode, 5);
    pulse(wakeReq);
    chk("R8 wake to 3", stateCode, 3);
    chk("R8 write ignored sel", cpuClkSel, 1);
    chk("R8 write no err", errFlag, 0);
    chk("R10 wdt back", wdtClkEn, 1);
  endtask

  task automatic tStop();
    doReset(0);
    doWrite(0, 0, 0);
    pulse(stabDone);
    pulse(stopReq);
    chk("R8 stop code", stateCode, 6);
    chk("R9 main off stop", mainOscEn, 0);
    chk("R10 ring on stop", ringOscEn, 1);
    chk("R10 wdt off stop", wdtClkEn, 0);
    pulse(wakeReq);
    chk("R8 wake to 2", stateCode, 2);
    chk("R9 main back", mainOscEn, 1);
    doWrite(0, 1, 0);
    chk("R9 requalify code", stateCode, 2);
    chk("R9 requalify err", errFlag, 1);
    doReset(0);
    haltReq = 1'b1; stopReq = 1'b1;
    cyc(1);
    haltReq = 1'b0; stopReq = 1'b0;
    chk("R8 stop priority", stateCode, 6);
    pulse(wakeReq);
    pulse(wakeReq);
    chk("R8 wake in run", stateCode, 1);
  endtask

  task automatic tStrap0();
    strapRingSw = 1'b0;
    doReset(0);
    pulse(haltReq);
    chk("R11 halt code", stateCode, 5);
    chk("R11 wdt on", wdtClkEn, 1);
    pulse(wakeReq);
    goState3();
    doWrite(0, 1, 1);
    chk("R11 ring stop reject", stateCode, 3);
    chk("R11 ring on", ringOscEn, 1);
    chk("R11 reject err", errFlag, 1);
    strapRingSw = 1'b1;
  endtask

  task automatic tRstSrcs();
    for (int i = 0; i < 5; i++) begin
      doWrite(0, 0, 0);
      doReset(i);
      chk($sformatf("R1 source %0d", i), stateCode, 1);
    end
  endtask

  initial begin
    tReset();
    tMainOsc();
    tSelect();
    tRing();
    tIllegal();
    tHalt();
    tStop();
    tStrap0();
    tRstSrcs();
    cyc(2);
    doneRun = 1'b1;
    finishRun();
  end

endmodule